// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the effective address for a four-beat burst into a synchronous memory. When either of two active-low address strobes is sampled low, it captures the full external address. The two least significant bits become the burst start value, and the upper bits are held for the rest of the burst. On each later clock edge where the active-low advance input is low, the low two bits move on to the next beat. Where advance is high, they stay where they are, which forms a wait state.

A static order-select input chooses the beat ordering. With order_sel low, the low bits count upward modulo four from the start value. With order_sel high, each beat is the start value XOR the beat index. Internally the block keeps the start value and a two-bit beat index. The index clears on every load and wraps after four beats, so a burst that keeps advancing cycles through the same four addresses again. A strobe always wins over advance, so a new load aborts any burst in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low and after its release with no strobe, addr_out is all zeros.
- R2: If strobe_p_n or strobe_c_n (either one alone, or both) is low at a rising clock edge, addr_out equals the addr_in sampled at that edge from that edge onward.
- R3: With order_sel = 0 (linear), each rising edge with adv_n low and both strobes high sets the low two bits of addr_out to their previous value plus one, modulo four. For example, start 01 gives 01, 10, 11, 00.
- R4: With order_sel = 1 (interleaved), the k-th beat (k = 0..3) of a burst from start value s has low two bits s XOR k. For example, start 10 gives 10, 11, 00, 01.
- R5: After four advances the low bits return to the start value, and further advances repeat the same four-beat sequence.
- R6: A rising edge with adv_n high and both strobes high leaves addr_out unchanged.
- R7: The upper ADDR_W-2 bits of addr_out stay equal to those loaded by the last strobe for as long as no new strobe is sampled.
- R8: A strobe sampled in the same cycle as adv_n low loads the new address unadvanced, aborting the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address, sampled when a strobe is low |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| order_sel | input | 1 | Static beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Effective address: loaded upper bits and sequenced low bits |

## Verification
Every result appears one rising edge after its stimulus. A load, an advance or a hold sampled at edge n shows on addr_out just after edge n, and only the order_sel selection is combinational on top of registered state. The bench drives inputs on the falling edge and samples addr_out on the following falling edge, exactly one register stage later. For each mode and start value, it walks a table of four expected beats, with a hold cycle inserted and a fifth advance that checks the wrap.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic [1:0]      low;
  logic            load;

  assign load = !strobe_p_n || !strobe_c_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      beat_q  <= '0;
    end else if (!adv_n) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low      = order_sel ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {hi_q, low};

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (order_sel != $past(order_sel)) || (addr_out == $past(addr_in)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> (order_sel != $past(order_sel)) || $stable(addr_out));

  // R3
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !order_sel) |=> order_sel || (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R4
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && order_sel) |=> !order_sel || (addr_out[1:0] != $past(addr_out[1:0])));

  // R7
  upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  // {order_sel, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0}
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic strobe_p_n = 1, strobe_c_n = 1, adv_n = 1, order_sel = 0;
  logic [AW-1:0] addr_out;
  int tests = 0, fails = 0, cycles = 0;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n), .adv_n(adv_n), .order_sel(order_sel), .addr_out(addr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [AW-1:0] base;
    @(negedge clk);
    check("R1 in reset", addr_out, '0);
    step();
    rst_n = 1;
    step();
    check("R1 after release", addr_out, '0);

    for (int i = 0; i < 8; i++) begin
      base = 16'hA5C0 + 16'(i * 16'h0104);
      order_sel = VEC[i][10];
      addr_in = {base[AW-1:2], VEC[i][9:8]};
      if (i % 2 == 0) strobe_p_n = 0; else strobe_c_n = 0;
      adv_n = 1;
      step();
      strobe_p_n = 1; strobe_c_n = 1;
      addr_in = 16'hFFFF;
      check("R2 load beat0", addr_out, {base[AW-1:2], VEC[i][7:6]});
      adv_n = 0;
      step();
      check(VEC[i][10] ? "R4 beat1" : "R3 beat1", addr_out, {base[AW-1:2], VEC[i][5:4]});
      adv_n = 1;
      step();
      check("R6 hold", addr_out, {base[AW-1:2], VEC[i][5:4]});
      adv_n = 0;
      step();
      check(VEC[i][10] ? "R4 beat2" : "R3 beat2", addr_out, {base[AW-1:2], VEC[i][3:2]});
      step();
      check(VEC[i][10] ? "R4 beat3" : "R3 beat3", addr_out, {base[AW-1:2], VEC[i][1:0]});
      step();
      check("R5 wrap", addr_out, {base[AW-1:2], VEC[i][7:6]});
      step();
      check("R7 upper kept", {addr_out[AW-1:2], 2'b00}, {base[AW-1:2], 2'b00});
      adv_n = 1;
    end

    order_sel = 0;
    addr_in = 16'h1231;
    strobe_c_n = 0;
    step();
    strobe_c_n = 1;
    adv_n = 0;
    step();
    step();
    check("R3 mid burst", addr_out, 16'h1233);
    addr_in = 16'h4562;
    strobe_p_n = 0;
    step();
    check("R8 load overrides advance", addr_out, 16'h4562);
    strobe_p_n = 1;
    step();
    check("R8 new burst steps", addr_out, 16'h4563);
    addr_in = 16'h7773;
    strobe_p_n = 0; strobe_c_n = 0;
    step();
    check("R2 both strobes", addr_out, 16'h7773);
    strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
    rst_n = 0;
    step();
    check("R1 reset clears", addr_out, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule